// File: doc/BRIEF.md
# Single-Cycle Main Control Decoder

This block is the primary control unit of a small single-cycle 32-bit load/store processor. It looks at the current instruction word and produces the selector and enable lines that steer the datapath for that instruction. It drives the destination-register choice, the second-operand choice for the ALU, the write-back source, and the register-file write enable. It also drives the data-memory read and write enables, a branch flag, and a 2-bit operation class. A second-stage ALU decoder uses that operation class together with the function field.

The block is purely combinational. It also forms the program-counter source select: the branch flag is gated with the zero flag that the ALU returns. Four instruction classes are recognised: register-to-register (R-format), load word, store word and branch-if-equal. Any other opcode produces an inert setting with every enable low, so a stray opcode can never write the register file or memory.

A parameter chooses the internal structure of the decoder. One variant is a two-level AND/OR array built from one-hot opcode matches. The other is a table-style selection. Both variants give identical outputs.

Top module: `sc_main_ctrl`

## Requirements
- R1: With opcode (instruction bits 31:26) 000000 (R-format): reg_dst=1, alu_src=0, wb_from_mem=0, rf_we=1, dm_re=0, dm_we=0, is_branch=0, alu_class=10.
- R2: With opcode 100011 (load word): reg_dst=0, alu_src=1, wb_from_mem=1, rf_we=1, dm_re=1, dm_we=0, is_branch=0, alu_class=00.
- R3: With opcode 101011 (store word): alu_src=1, dm_we=1, and every other output 0 (reg_dst and wb_from_mem, which are don't-cares, are driven 0), alu_class=00.
- R4: With opcode 000100 (branch-if-equal): is_branch=1, alu_class=01, and all other outputs 0.
- R5: For any other opcode, every output is 0, including alu_class=00 and pc_branch.
- R6: pc_branch is 1 exactly when is_branch is 1 and alu_zero is 1. A value of 1 selects the branch target and a value of 0 selects PC+4.
- R7: Instruction bits 25:0, which include the function field, have no effect on any output.
- R8: dm_re and dm_we are never high together, and rf_we is never high while dm_we or is_branch is high.
- R9: alu_zero has no effect on any output other than pc_branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Current instruction word; the opcode is bits 31:26 |
| alu_zero_i | input | 1 | Zero flag from the ALU |
| reg_dst_o | output | 1 | 1: destination register comes from bits 15:11; 0: from bits 20:16 |
| alu_src_o | output | 1 | 1: second ALU operand is the sign-extended immediate |
| wb_from_mem_o | output | 1 | 1: register write data comes from data memory |
| rf_we_o | output | 1 | Register-file write enable |
| dm_re_o | output | 1 | Data-memory read enable |
| dm_we_o | output | 1 | Data-memory write enable |
| is_branch_o | output | 1 | Instruction is a conditional branch |
| alu_class_o | output | 2 | Operation class passed to the ALU decoder |
| pc_branch_o | output | 1 | PC source select: 1 selects the branch target |

## Verification
The bench sweeps all 64 opcodes, each with both values of the zero flag and random lower instruction bits. This exposes a decoder that matches on too few opcode bits, because such a design would alias an unused opcode onto load or store and enable a spurious memory or register write. Pairs of instructions that share an opcode but differ in their low 26 bits catch a decoder that wrongly reads the function field. Toggling the zero flag on non-branch opcodes catches a PC select that is not gated by the branch flag, which would send a taken branch on an ordinary ALU result of zero. Don't-care outputs are compared against 0, so a store or branch that leaks a write-back select is also caught.

// File: rtl/sc_ctrl_pkg.sv
package sc_ctrl_pkg;

   localparam int OPC_W   = 6;
   localparam int CLASS_W = 2;
   localparam int N_KINDS = 4;

   // index of each recognised instruction kind in the one-hot match vector
   localparam int K_REG   = 0;
   localparam int K_LOAD  = 1;
   localparam int K_STORE = 2;
   localparam int K_BEQ   = 3;

   localparam logic [OPC_W-1:0] OPC_REG   = 6'b000000;
   localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
   localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
   localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;

   // codes packed in kind order, kind 0 in the low slice
   localparam logic [N_KINDS*OPC_W-1:0] OPC_TABLE =
      {OPC_BEQ, OPC_STORE, OPC_LOAD, OPC_REG};

   localparam logic [CLASS_W-1:0] CLS_ADD  = 2'b00;
   localparam logic [CLASS_W-1:0] CLS_SUB  = 2'b01;
   localparam logic [CLASS_W-1:0] CLS_FUNC = 2'b10;

   typedef struct packed {
      logic                reg_dst;
      logic                alu_src;
      logic                wb_from_mem;
      logic                rf_we;
      logic                dm_re;
      logic                dm_we;
      logic                is_branch;
      logic [CLASS_W-1:0]  alu_class;
   } ctrl_t;

   localparam ctrl_t CTRL_IDLE = '0;

endpackage

// File: rtl/sc_ctrl_match.sv
module sc_ctrl_match
   import sc_ctrl_pkg::*;
#(
   parameter int W = OPC_W,
   parameter int N = N_KINDS,
   parameter logic [N*W-1:0] CODES = OPC_TABLE
)(
   input  logic [W-1:0] opcode_i,
   output logic [N-1:0] hit_o
);

   if (W < 1) begin : g_bad_w
      $error("sc_ctrl_match: W must be positive");
   end

   // AND plane: one full-width product term per recognised opcode
   for (genvar k = 0; k < N; k++) begin : g_term
      assign hit_o[k] = (opcode_i == CODES[k*W +: W]);
   end

endmodule

// File: rtl/sc_ctrl_plane.sv
module sc_ctrl_plane
   import sc_ctrl_pkg::*;
#(
   parameter bit USE_ARRAY = 1'b1
)(
   input  logic [N_KINDS-1:0] hit_i,
   output ctrl_t              ctrl_o
);

   if (USE_ARRAY) begin : g_array
      // OR plane: each output ORs the product terms of the kinds that need it
      always_comb begin
         ctrl_o              = CTRL_IDLE;
         ctrl_o.reg_dst      = hit_i[K_REG];
         ctrl_o.alu_src      = hit_i[K_LOAD] | hit_i[K_STORE];
         ctrl_o.wb_from_mem  = hit_i[K_LOAD];
         ctrl_o.rf_we        = hit_i[K_REG] | hit_i[K_LOAD];
         ctrl_o.dm_re        = hit_i[K_LOAD];
         ctrl_o.dm_we        = hit_i[K_STORE];
         ctrl_o.is_branch    = hit_i[K_BEQ];
         ctrl_o.alu_class[1] = hit_i[K_REG];
         ctrl_o.alu_class[0] = hit_i[K_BEQ];
      end
   end else begin : g_table
      always_comb begin
         ctrl_o = CTRL_IDLE;
         if (hit_i[K_REG]) begin
            ctrl_o.reg_dst   = 1'b1;
            ctrl_o.rf_we     = 1'b1;
            ctrl_o.alu_class = CLS_FUNC;
         end else if (hit_i[K_LOAD]) begin
            ctrl_o.alu_src     = 1'b1;
            ctrl_o.wb_from_mem = 1'b1;
            ctrl_o.rf_we       = 1'b1;
            ctrl_o.dm_re       = 1'b1;
            ctrl_o.alu_class   = CLS_ADD;
         end else if (hit_i[K_STORE]) begin
            ctrl_o.alu_src   = 1'b1;
            ctrl_o.dm_we     = 1'b1;
            ctrl_o.alu_class = CLS_ADD;
         end else if (hit_i[K_BEQ]) begin
            ctrl_o.is_branch = 1'b1;
            ctrl_o.alu_class = CLS_SUB;
         end
      end
   end

endmodule

// File: rtl/sc_ctrl_pcsel.sv
module sc_ctrl_pcsel (
   input  logic is_branch_i,
   input  logic zero_i,
   output logic take_o
);

   assign take_o = is_branch_i & zero_i;

endmodule

// File: rtl/sc_main_ctrl.sv
module sc_main_ctrl
   import sc_ctrl_pkg::*;
#(
   parameter int INSTR_W   = 32,
   parameter int OPC_LSB   = 26,
   parameter bit USE_ARRAY = 1'b1,
   localparam int OPC_MSB  = OPC_LSB + OPC_W - 1
)(
   input  logic [INSTR_W-1:0] instr_i,
   input  logic               alu_zero_i,
   output logic               reg_dst_o,
   output logic               alu_src_o,
   output logic               wb_from_mem_o,
   output logic               rf_we_o,
   output logic               dm_re_o,
   output logic               dm_we_o,
   output logic               is_branch_o,
   output logic [CLASS_W-1:0] alu_class_o,
   output logic               pc_branch_o
);

   if (OPC_MSB >= INSTR_W) begin : g_bad_field
      $error("sc_main_ctrl: opcode field exceeds instruction width");
   end
   if (CLASS_W != 2) begin : g_bad_class
      $error("sc_main_ctrl: operation class must be 2 bits");
   end

   logic [OPC_W-1:0]   opcode;
   logic [N_KINDS-1:0] hit;
   ctrl_t              ctrl;

   assign opcode = instr_i[OPC_MSB:OPC_LSB];

   sc_ctrl_match #(
      .W     (OPC_W),
      .N     (N_KINDS),
      .CODES (OPC_TABLE)
   ) u_match (
      .opcode_i (opcode),
      .hit_o    (hit)
   );

   sc_ctrl_plane #(
      .USE_ARRAY (USE_ARRAY)
   ) u_plane (
      .hit_i  (hit),
      .ctrl_o (ctrl)
   );

   sc_ctrl_pcsel u_pcsel (
      .is_branch_i (ctrl.is_branch),
      .zero_i      (alu_zero_i),
      .take_o      (pc_branch_o)
   );

   assign reg_dst_o     = ctrl.reg_dst;
   assign alu_src_o     = ctrl.alu_src;
   assign wb_from_mem_o = ctrl.wb_from_mem;
   assign rf_we_o       = ctrl.rf_we;
   assign dm_re_o       = ctrl.dm_re;
   assign dm_we_o       = ctrl.dm_we;
   assign is_branch_o   = ctrl.is_branch;
   assign alu_class_o   = ctrl.alu_class;

endmodule

// File: rtl/sc_main_ctrl_chk.sv
module sc_main_ctrl_chk
   import sc_ctrl_pkg::*;
(
   input logic [31:0]        instr_i,
   input logic               alu_zero_i,
   input logic               reg_dst_o,
   input logic               wb_from_mem_o,
   input logic               rf_we_o,
   input logic               dm_re_o,
   input logic               dm_we_o,
   input logic               is_branch_o,
   input logic [CLASS_W-1:0] alu_class_o,
   input logic               pc_branch_o
);

   logic known;
   assign known = (instr_i[31:26] == OPC_REG)  || (instr_i[31:26] == OPC_LOAD) ||
                  (instr_i[31:26] == OPC_STORE) || (instr_i[31:26] == OPC_BEQ);

   always_comb begin
      a_r8_mem_exclusive: assert (!(dm_re_o && dm_we_o))
         else $error("dm_re and dm_we both high");
      a_r8_no_rf_on_store: assert (!(rf_we_o && (dm_we_o || is_branch_o)))
         else $error("register write with store or branch");
      a_r6_pc_gate: assert (pc_branch_o == (is_branch_o && alu_zero_i))
         else $error("pc select not gated by branch and zero");
      a_r5_unknown_idle: assert (known || !(rf_we_o || dm_re_o || dm_we_o || is_branch_o
                                            || pc_branch_o || reg_dst_o || wb_from_mem_o
                                            || (alu_class_o != 2'b00)))
         else $error("unknown opcode raised a control line");
      a_r4_branch_class: assert (!is_branch_o || (alu_class_o == CLS_SUB))
         else $error("branch with wrong operation class");
   end

endmodule

bind sc_main_ctrl sc_main_ctrl_chk u_chk (
   .instr_i       (instr_i),
   .alu_zero_i    (alu_zero_i),
   .reg_dst_o     (reg_dst_o),
   .wb_from_mem_o (wb_from_mem_o),
   .rf_we_o       (rf_we_o),
   .dm_re_o       (dm_re_o),
   .dm_we_o       (dm_we_o),
   .is_branch_o   (is_branch_o),
   .alu_class_o   (alu_class_o),
   .pc_branch_o   (pc_branch_o)
);

// File: tb/sc_main_ctrl_bench.sv
module sc_main_ctrl_bench;

   logic        clk = 1'b0;
   logic [31:0] instr = '0;
   logic        zero = 1'b0;
   logic        reg_dst, alu_src, wb_mem, rf_we, dm_re, dm_we, is_br, pc_br;
   logic [1:0]  alu_class;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   sc_main_ctrl u_sc_main_ctrl (
      .instr_i       (instr),
      .alu_zero_i    (zero),
      .reg_dst_o     (reg_dst),
      .alu_src_o     (alu_src),
      .wb_from_mem_o (wb_mem),
      .rf_we_o       (rf_we),
      .dm_re_o       (dm_re),
      .dm_we_o       (dm_we),
      .is_branch_o   (is_br),
      .alu_class_o   (alu_class),
      .pc_branch_o   (pc_br)
   );

   // packed observation order: reg_dst alu_src wb_mem rf_we dm_re dm_we is_br class[1:0] pc_br
   function automatic logic [9:0] observed();
      return {reg_dst, alu_src, wb_mem, rf_we, dm_re, dm_we, is_br, alu_class, pc_br};
   endfunction

   // reference model written from the requirement list
   function automatic logic [9:0] expect_of(input logic [5:0] op, input logic z);
      logic [9:0] e;
      e = '0;
      if (op == 6'd0)       e = 10'b1_0_0_1_0_0_0_10_0;     // R1
      else if (op == 6'd35) e = 10'b0_1_1_1_1_0_0_00_0;     // R2
      else if (op == 6'd43) e = 10'b0_1_0_0_0_1_0_00_0;     // R3
      else if (op == 6'd4)  e = {7'b0_0_0_0_0_0_1, 2'b01, z}; // R4, R6
      return e;                                            // R5 otherwise
   endfunction

   function automatic string tag_of(input logic [5:0] op);
      if (op == 6'd0)  return "R1";
      if (op == 6'd35) return "R2";
      if (op == 6'd43) return "R3";
      if (op == 6'd4)  return "R4/R6";
      return "R5";
   endfunction

   task automatic check(input logic [9:0] act, input logic [9:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s instr=%h zero=%b actual=%b expected=%b", tag, instr, zero, act, exp);
      end
   endtask

   task automatic apply(input logic [31:0] ins, input logic z);
      @(posedge clk);
      instr = ins;
      zero  = z;
      @(negedge clk);
   endtask

   initial begin
      logic [9:0] first;
      // reset-like idle state: an unused opcode drives nothing (R5)
      apply({6'b111111, 26'h0}, 1'b1);
      check(observed(), 10'b0, "R5 idle");

      // full opcode sweep, both zero values, random low bits (R1..R6)
      for (int op = 0; op < 64; op++) begin
         for (int z = 0; z < 2; z++) begin
            apply({op[5:0], 26'($urandom)}, z[0]);
            check(observed(), expect_of(op[5:0], z[0]), tag_of(op[5:0]));
         end
      end

      // R7: low 26 bits ignored for each recognised opcode
      foreach (sc_ctrl_pkg::OPC_TABLE[i]) begin
         if (i % 6 == 0) begin
            logic [5:0] op;
            op = sc_ctrl_pkg::OPC_TABLE[i +: 6];
            apply({op, 26'h0000000}, 1'b1);
            first = observed();
            apply({op, 26'h3ffffff}, 1'b1);
            check(observed(), first, "R7 low bits");
            check(observed(), expect_of(op, 1'b1), "R7 value");
         end
      end

      // R9: zero flag toggled on non-branch opcodes changes nothing
      apply({6'd0, 26'h1234}, 1'b0);
      first = observed();
      apply({6'd0, 26'h1234}, 1'b1);
      check(observed(), first, "R9 R-format");
      apply({6'd35, 26'h55}, 1'b1);
      check(observed(), expect_of(6'd35, 1'b0), "R9 load");

      // R6: branch taken vs not taken
      apply({6'd4, 26'h0}, 1'b1);
      check({9'b0, pc_br}, 10'd1, "R6 taken");
      apply({6'd4, 26'h0}, 1'b0);
      check({9'b0, pc_br}, 10'd0, "R6 not taken");

      // R8: mutual exclusion across the sweep
      for (int op = 0; op < 64; op++) begin
         apply({op[5:0], 26'h0}, 1'b1);
         check({9'b0, (dm_re & dm_we) | (rf_we & (dm_we | is_br))}, 10'd0, "R8");
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule